// File: doc/BRIEF.md
# Text Page Write-to-Display Mapper

This block sits beside a CPU write port and watches every write transaction. A write whose address lands in the 1 KB text page, from 0x0400 to 0x07FF, is turned into one display-update event. The event names the screen position as a row and a column. It also carries a 6-bit character code and a 2-bit display attribute. A downstream display writer uses these to repaint a single character cell.

The text page is interleaved. The page is cut into eight 128-byte chunks. Inside a chunk, three runs of 40 bytes map to three screen rows that lie 8 rows apart. The last 8 bytes of each chunk are not shown on screen, so a write there makes no event.

Events wait in a small two-entry buffer. The buffer drives a valid/ready handshake towards the display writer. A mapped write that finds the buffer full, while no event leaves in the same cycle, is lost. A sticky overflow flag records the loss.

Top module: `txt_page_mapper`

## Requirements
- R1: A write makes an event only when `wr_en` is high and `wr_addr` lies in 0x0400..0x07FF. An address outside that range, or a cycle with `wr_en` low, never makes an event.
- R2: The offset is `wr_addr` − 0x0400. The chunk index is offset/128 and the in-chunk byte is offset mod 128. The band is the in-chunk byte / 40. The event has `ev_col` = in-chunk byte mod 40 and `ev_row` = chunk index + 8 × band. Rows run from 0 to 23 and columns from 0 to 39.
- R3: Up to two events are held. A mapped write that finds two events held, with no handshake in that cycle, is dropped and sets `overflow`. `overflow` stays high until reset. A mapped write in a cycle where a held event is handed over is kept.
- R4: A write to in-chunk bytes 120..127 makes no event. It does not set `overflow`, even when the buffer is full.
- R5: `ev_code` = (`wr_data` + 0x20) mod 64.
- R6: The `ev_attr` encoding is 0 = dim, 1 = reverse, 2 = underline. Data 0x00..0x3F gives 0, 0x40..0x7F gives 1, 0x80..0x9F gives 2, and 0xA0..0xFF gives 0.
- R7: Once `ev_valid` is high, it stays high until a cycle with `ev_ready` high. While it waits, `ev_row`, `ev_col`, `ev_code` and `ev_attr` do not change. Events leave in the order of their writes.
- R8: While `rst` is high, and in the cycle after it, `ev_valid` and `overflow` are low and the buffer is empty.
- R9: A mapped write into a non-full buffer raises `ev_valid` in the cycle after the clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Display writer takes the event |
| ev_row | output | 5 | Screen row 0..23 |
| ev_col | output | 6 | Screen column 0..39 |
| ev_code | output | 6 | Character code |
| ev_attr | output | 2 | Display attribute |
| overflow | output | 1 | Sticky: an event was dropped |

## Verification
The hardest state to reach from the ports is a full buffer at the moment a new write arrives. The bench gets there by holding `ev_ready` low across two mapped writes. It then offers a hidden-hole write, which must not set `overflow`, and a third mapped write, which must be dropped and must set `overflow`. After a reset, the same full state is built again, this time with `ev_ready` raised in the cycle of the third write, so the event has to be kept. A long run with interleaved writes and a toggling ready then walks addresses across and around the page. Every delivered event is compared against a scoreboard.

// File: rtl/txt_map_pkg.sv
package txt_map_pkg;

    localparam int DATA_W = 8;
    localparam int ROWS   = 24;
    localparam int COLS   = 40;
    localparam int ROW_W  = 5;
    localparam int COL_W  = 6;
    localparam int CODE_W = 6;

    typedef enum logic [1:0] {
        ATTR_DIM       = 2'd0,
        ATTR_REVERSE   = 2'd1,
        ATTR_UNDERLINE = 2'd2
    } attr_e;

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [CODE_W-1:0] code;
        attr_e             attr;
    } cell_ev_t;

    // Character code: data shifted by 0x20, wrapped to 6 bits
    function automatic logic [CODE_W-1:0] code_of(input logic [DATA_W-1:0] d);
        return d[CODE_W-1:0] + CODE_W'(6'h20);
    endfunction

    // Attribute from data value bands
    function automatic attr_e attr_of(input logic [DATA_W-1:0] d);
        if (d < 8'h40)      return ATTR_DIM;
        else if (d < 8'h80) return ATTR_REVERSE;
        else if (d < 8'hA0) return ATTR_UNDERLINE;
        else                return ATTR_DIM;
    endfunction

endpackage

// File: rtl/txt_addr_decode.sv
module txt_addr_decode
    import txt_map_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_BASE   = 'h0400,
    parameter int PAGE_BYTES  = 1024,
    parameter int CHUNK_BYTES = 128
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hit,
    output cell_ev_t          ev
);
    localparam int OFF_W    = $clog2(PAGE_BYTES);
    localparam int LO_W     = $clog2(CHUNK_BYTES);
    localparam int HI_W     = OFF_W - LO_W;
    localparam int GROUPS   = CHUNK_BYTES / COLS;
    localparam int GRP_W    = $clog2(GROUPS + 1);
    localparam int ROW_STEP = PAGE_BYTES / CHUNK_BYTES;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(PAGE_BASE);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(PAGE_BASE + PAGE_BYTES - 1);

    logic [OFF_W-1:0] rel;
    logic [HI_W-1:0]  hi;
    logic [LO_W-1:0]  lo;
    logic [GRP_W-1:0] grp;
    logic             in_page;
    logic             hole;

    assign rel = OFF_W'(wr_addr - BASE_A);
    assign hi  = rel[OFF_W-1:LO_W];
    assign lo  = rel[LO_W-1:0];

    // Band select: the highest band whose start is at or below lo
    always_comb begin
        grp = '0;
        for (int g = 1; g <= GROUPS; g++) begin
            if (int'(lo) >= g * COLS) grp = GRP_W'(g);
        end
    end

    assign hole    = (int'(grp) == GROUPS);
    assign in_page = (wr_addr >= BASE_A) && (wr_addr <= LAST_A);
    assign hit     = wr_en && in_page && !hole;

    always_comb begin
        ev.row  = ROW_W'(int'(hi) + int'(grp) * ROW_STEP);
        ev.col  = COL_W'(int'(lo) - int'(grp) * COLS);
        ev.code = code_of(wr_data);
        ev.attr = attr_of(wr_data);
    end

endmodule

// File: rtl/txt_event_fifo.sv
module txt_event_fifo
    import txt_map_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  cell_ev_t push_ev,
    input  logic     pop,
    output logic     out_valid,
    output cell_ev_t out_ev,
    output logic     dropped
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    cell_ev_t          slots [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [CNT_W-1:0]  cnt;
    logic              full, take, accept;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (cnt == CNT_W'(DEPTH));
    assign take    = pop && (cnt != '0);
    assign accept  = push && (!full || take);
    assign dropped = push && full && !take;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (accept) wp <= ptr_next(wp);
            if (take)   rp <= ptr_next(rp);
            case ({accept, take})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (accept) slots[wp] <= push_ev;
    end

    assign out_valid = (cnt != '0);
    assign out_ev    = slots[rp];

endmodule

// File: rtl/txt_page_mapper.sv
module txt_page_mapper
    import txt_map_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_BASE   = 'h0400,
    parameter int PAGE_BYTES  = 1024,
    parameter int CHUNK_BYTES = 128,
    parameter int EV_DEPTH    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ev_valid,
    input  logic              ev_ready,
    output logic [ROW_W-1:0]  ev_row,
    output logic [COL_W-1:0]  ev_col,
    output logic [CODE_W-1:0] ev_code,
    output logic [1:0]        ev_attr,
    output logic              overflow
);
    logic     hit;
    cell_ev_t new_ev;
    cell_ev_t head_ev;
    logic     dropped;
    logic     overflow_q;

    txt_addr_decode #(
        .ADDR_W      (ADDR_W),
        .PAGE_BASE   (PAGE_BASE),
        .PAGE_BYTES  (PAGE_BYTES),
        .CHUNK_BYTES (CHUNK_BYTES)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hit     (hit),
        .ev      (new_ev)
    );

    txt_event_fifo #(
        .DEPTH (EV_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (hit),
        .push_ev   (new_ev),
        .pop       (ev_ready),
        .out_valid (ev_valid),
        .out_ev    (head_ev),
        .dropped   (dropped)
    );

    always_ff @(posedge clk) begin
        if (rst)          overflow_q <= 1'b0;
        else if (dropped) overflow_q <= 1'b1;
    end

    assign overflow = overflow_q;
    assign ev_row   = head_ev.row;
    assign ev_col   = head_ev.col;
    assign ev_code  = head_ev.code;
    assign ev_attr  = head_ev.attr;

endmodule

// File: rtl/txt_page_mapper_chk.sv
module txt_page_mapper_chk #(
    parameter int ADDR_W      = 16,
    parameter int PAGE_BASE   = 'h0400,
    parameter int PAGE_BYTES  = 1024,
    parameter int CHUNK_BYTES = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic [4:0]        ev_row,
    input logic [5:0]        ev_col,
    input logic [5:0]        ev_code,
    input logic [1:0]        ev_attr,
    input logic              overflow
);
    localparam int LO_W = $clog2(CHUNK_BYTES);
    localparam int SHOWN = (CHUNK_BYTES / 40) * 40;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(PAGE_BASE);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(PAGE_BASE + PAGE_BYTES - 1);

    logic              page_wr;
    logic [ADDR_W-1:0] rel;
    logic              shown_wr;

    assign page_wr  = wr_en && (wr_addr >= BASE_A) && (wr_addr <= LAST_A);
    assign rel      = wr_addr - BASE_A;
    assign shown_wr = page_wr && (int'(rel[LO_W-1:0]) < SHOWN);

    // R1: nothing appears from an empty buffer without an in-page write
    assert_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (!ev_valid && !page_wr) |=> !ev_valid);

    // R2: events stay on the visible grid
    assert_grid_R2: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> (ev_row < 5'd24) && (ev_col < 6'd40));

    // R3: overflow is sticky
    assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R7: valid held with stable fields until taken
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !ev_ready) |=> ev_valid && $stable({ev_row, ev_col, ev_code, ev_attr}));

    // R8: reset empties the buffer and clears the flag
    assert_reset_R8: assert property (@(posedge clk)
        rst |=> (!ev_valid && !overflow));

    // R9: a shown write into an empty buffer appears next cycle
    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        (!ev_valid && shown_wr) |=> ev_valid);

endmodule

bind txt_page_mapper txt_page_mapper_chk #(
    .ADDR_W      (ADDR_W),
    .PAGE_BASE   (PAGE_BASE),
    .PAGE_BYTES  (PAGE_BYTES),
    .CHUNK_BYTES (CHUNK_BYTES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .ev_valid (ev_valid),
    .ev_ready (ev_ready),
    .ev_row   (ev_row),
    .ev_col   (ev_col),
    .ev_code  (ev_code),
    .ev_attr  (ev_attr),
    .overflow (overflow)
);

// File: tb/txt_page_mapper_test.sv
module txt_page_mapper_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ev_ready = 1'b0;
    logic        ev_valid;
    logic [4:0]  ev_row;
    logic [5:0]  ev_col;
    logic [5:0]  ev_code;
    logic [1:0]  ev_attr;
    logic        overflow;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [18:0] sb[$];

    always #10 clk = ~clk;

    txt_page_mapper uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_row(ev_row), .ev_col(ev_col),
        .ev_code(ev_code), .ev_attr(ev_attr), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit ref_hit(input int a);
        int off = a - 'h400;
        return (off >= 0) && (off < 1024) && ((off % 128) < 120);
    endfunction

    function automatic logic [18:0] ref_ev(input int a, input int d);
        int off = a - 'h400;
        int hi = off / 128;
        int lo = off % 128;
        int g = lo / 40;
        int row = hi + 8 * g;
        int col = lo % 40;
        int code = (d + 32) % 64;
        int attr = (d < 'h40) ? 0 : (d < 'h80) ? 1 : (d < 'hA0) ? 2 : 0;
        return {row[4:0], col[5:0], code[5:0], attr[1:0]};
    endfunction

    // Driver: called at posedge+2, returns at the next posedge+2
    task automatic do_write(input int a, input int d, input bit keep);
        wr_addr = a[15:0];
        wr_data = d[7:0];
        wr_en   = 1'b1;
        if (keep && ref_hit(a)) sb.push_back(ref_ev(a, d));
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    // Monitor: compares each handed-over event with the scoreboard head
    always @(negedge clk) begin
        if (!rst && ev_valid && ev_ready) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7 unexpected event", {ev_row, ev_col}, 0);
            end else begin
                logic [18:0] e;
                e = sb.pop_front();
                chk(ev_row == e[18:14], "R2 row", ev_row, e[18:14]);
                chk(ev_col == e[13:8], "R2 col", ev_col, e[13:8]);
                chk(ev_code == e[7:2], "R5 code", ev_code, e[7:2]);
                chk(ev_attr == e[1:0], "R6 attr", ev_attr, e[1:0]);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        @(negedge clk);
        chk(!ev_valid, "R8 valid in reset", ev_valid, 0);
        chk(!overflow, "R8 overflow in reset", overflow, 0);
        @(posedge clk); #2;
        rst = 1'b0;
        @(negedge clk);
        chk(!ev_valid, "R8 valid after reset", ev_valid, 0);
        @(posedge clk); #2;

        // R1: ignored writes; R4: hidden holes
        ev_ready = 1'b0;
        do_write('h03FF, 'h41, 1);
        do_write('h0800, 'h41, 1);
        wr_addr = 16'h0400; wr_data = 8'h41; wr_en = 1'b0;
        step(1);
        @(negedge clk);
        chk(!ev_valid, "R1 no event outside page or strobe low", ev_valid, 0);
        @(posedge clk); #2;
        do_write('h0478, 'h41, 1);
        do_write('h07FF, 'h41, 1);
        @(negedge clk);
        chk(!ev_valid, "R4 no event for hole bytes", ev_valid, 0);
        chk(!overflow, "R4 no overflow", overflow, 0);
        @(posedge clk); #2;

        // R9: latency of one cycle
        wr_addr = 16'h0400; wr_data = 8'hC1; wr_en = 1'b1;
        sb.push_back(ref_ev('h0400, 'hC1));
        @(negedge clk);
        chk(!ev_valid, "R9 not before capture edge", ev_valid, 0);
        @(posedge clk); #2;
        wr_en = 1'b0;
        @(negedge clk);
        chk(ev_valid, "R9 valid after capture edge", ev_valid, 1);
        @(posedge clk); #2;
        ev_ready = 1'b1;
        step(3);

        // R2, R5, R6: mapping corners and attribute bands
        do_write('h0427, 'h00, 1);
        do_write('h0428, 'h3F, 1);
        do_write('h0450, 'h40, 1);
        do_write('h0477, 'h7F, 1);
        do_write('h0480, 'h80, 1);
        do_write('h07D0, 'h9F, 1);
        do_write('h07F7, 'hA0, 1);
        do_write('h06A9, 'hFF, 1);
        step(4);

        // R7 hold, R3 overflow with R4 hole while full
        ev_ready = 1'b0;
        do_write('h0401, 'h12, 1);
        do_write('h0502, 'h55, 1);
        step(5);
        @(negedge clk);
        chk(ev_valid, "R7 valid held without ready", ev_valid, 1);
        @(posedge clk); #2;
        do_write('h047A, 'h20, 1);
        @(negedge clk);
        chk(!overflow, "R4 hole write while full", overflow, 0);
        @(posedge clk); #2;
        do_write('h0403, 'h66, 0);
        @(negedge clk);
        chk(overflow, "R3 drop sets overflow", overflow, 1);
        @(posedge clk); #2;
        ev_ready = 1'b1;
        step(4);
        @(negedge clk);
        chk(!ev_valid, "R3 dropped write not delivered", ev_valid, 0);
        chk(overflow, "R3 overflow sticky", overflow, 1);
        @(posedge clk); #2;

        // R8 reset clears; R3 push with simultaneous pop kept
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        @(negedge clk);
        chk(!overflow, "R8 overflow cleared", overflow, 0);
        @(posedge clk); #2;
        ev_ready = 1'b0;
        do_write('h0600, 'h01, 1);
        do_write('h0629, 'h02, 1);
        ev_ready = 1'b1;
        do_write('h0652, 'h03, 1);
        step(5);
        @(negedge clk);
        chk(!overflow, "R3 write kept when slot frees", overflow, 0);
        @(posedge clk); #2;

        // Mixed stream with toggling ready
        for (int i = 0; i < 900; i++) begin
            int a;
            int d;
            ev_ready = ~ev_ready;
            if (i % 3 == 0) begin
                a = int'($urandom_range(32'h08FF, 32'h0300));
                d = int'($urandom_range(32'hFF, 0));
                wr_addr = a[15:0]; wr_data = d[7:0]; wr_en = 1'b1;
                if (ref_hit(a)) sb.push_back(ref_ev(a, d));
            end else begin
                wr_en = 1'b0;
            end
            @(posedge clk); #2;
        end
        wr_en = 1'b0;
        ev_ready = 1'b1;
        step(8);
        chk(sb.size() == 0, "R7 all events delivered in order", sb.size(), 0);
        chk(!overflow, "R3 no overflow under light load", overflow, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule